// File: doc/BRIEF.md
# Two-Slot Partitioned Register File

This block is the register file of a two-slot long-instruction-word datapath. Its registers are split into banks, one bank for each issue slot. Each bank has exactly one write port, and that port belongs to its slot. Two results can therefore retire in the same cycle without any storage that has more than one write port.

Each slot reads two source operands every cycle. Operand A always comes from the slot's own bank. Operand B may name a register in either bank and reaches the slot through a bank multiplexer. Each bank therefore serves three reads at once: its own slot's A, its own slot's B, and the other slot's cross-bank B.

Reads are combinational. No bypass exists inside the block, so any forwarding is done by the surrounding pipeline. The bank count and the registers per bank are parameters. A four-bank build with sixteen registers per bank is an optional configuration.

Top module: `banked_regfile`

## Requirements
- R1: A register's global index is {bank, offset}. The bank is the high address bits and the offset is the low log2(REGS_PER_BANK) bits. With the defaults (2 banks of 16 registers, 5-bit address), bit 4 selects the bank, so index 0..15 is bank 0 and index 16..31 is bank 1.
- R2: When a slot's write enable is high and its write address lies in that slot's own bank, the data is stored at the clock edge. It is readable from the following cycle.
- R3: Both slots can write in the same cycle, each into its own bank, and both values are stored.
- R4: A write whose address lies outside the writing slot's bank is dropped. No register in any bank changes.
- R5: Such a dropped write sets that slot's bit of `badWrite` one cycle later. The bit stays set until reset, and the other slot's bit is not affected.
- R6: Operand A of a slot always reads the slot's own bank at the offset bits of `rdAddrA`. The bank bits of `rdAddrA` have no effect.
- R7: Operand B of a slot reads the register named by the full `rdAddrB`, in either bank.
- R8: A read of a register that is being written in the same cycle returns the old value until the clock edge, and the new value after it.
- R9: A synchronous active-high `rst` clears every register and both `badWrite` bits.
- R10: All four read outputs are valid at the same time. This includes both B operands and one A operand addressing the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdAddrA | input | NUM_SLOTS*ADDR_W | Operand A address per slot; only the offset bits are used |
| rdAddrB | input | NUM_SLOTS*ADDR_W | Operand B address per slot; full global index |
| rdDataA | output | NUM_SLOTS*DATA_W | Operand A data per slot |
| rdDataB | output | NUM_SLOTS*DATA_W | Operand B data per slot |
| wrEn | input | NUM_SLOTS | Write enable per slot |
| wrAddr | input | NUM_SLOTS*ADDR_W | Write address per slot; global index |
| wrData | input | NUM_SLOTS*DATA_W | Write data per slot |
| badWrite | output | NUM_SLOTS | Sticky flag per slot: an out-of-bank write was dropped |

## Verification
Two functions of this block can fall in the same cycle: a slot's write to a register, and a read of that same register through an A or B port. The bench provokes this by holding a read address on the target register while the write enable is raised for one cycle. It samples the read data just before the edge, where the old value is expected, and again just after the edge, where the new value is expected. A second overlap is a dropped foreign write in one slot alongside a legal write or read in the other. There the bench judges that only the legal slot's result lands and that only the offending slot's flag rises.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

  // Per-slot write strobes passed from control to datapath
  typedef struct packed {
    logic commit;  // store into own bank this edge
    logic reject;  // address was foreign; drop and flag
  } wrStrobe_t;

endpackage

// File: rtl/banked_regfile_ctrl.sv
module banked_regfile_ctrl
  import banked_regfile_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int OFF_W     = 4,
  parameter int BANK_W    = 1,
  localparam int ADDR_W   = OFF_W + BANK_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SLOTS-1:0]        wrEn,
  input  logic [NUM_SLOTS*ADDR_W-1:0] wrAddr,
  output wrStrobe_t                   strobe [NUM_SLOTS],
  output logic [OFF_W-1:0]            wrOff  [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0]        badWrite
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [BANK_W-1:0] wrBank;
    logic              ownBank;

    assign wrBank   = wrAddr[s*ADDR_W+OFF_W +: BANK_W];
    assign wrOff[s] = wrAddr[s*ADDR_W +: OFF_W];
    assign ownBank  = (wrBank == BANK_W'(s));

    always_comb begin
      strobe[s].commit = wrEn[s] && ownBank;
      strobe[s].reject = wrEn[s] && !ownBank;
    end

    always_ff @(posedge clk) begin
      if (rst)                   badWrite[s] <= 1'b0;
      else if (strobe[s].reject) badWrite[s] <= 1'b1;
    end

    // R5: once raised, the flag holds until reset
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      badWrite[s] |=> badWrite[s]);

    // R5: an enabled write aimed at another bank raises the flag next cycle
    p_flag_on_foreign_r5: assert property (@(posedge clk) disable iff (rst)
      (wrEn[s] && (wrAddr[s*ADDR_W+OFF_W +: BANK_W] != BANK_W'(s))) |=> badWrite[s]);
  end

endmodule

// File: rtl/banked_regfile_dp.sv
module banked_regfile_dp
  import banked_regfile_pkg::*;
#(
  parameter int NUM_SLOTS     = 2,
  parameter int REGS_PER_BANK = 16,
  parameter int DATA_W        = 32,
  parameter int OFF_W         = 4,
  parameter int BANK_W        = 1,
  localparam int ADDR_W       = OFF_W + BANK_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  wrStrobe_t                   strobe [NUM_SLOTS],
  input  logic [OFF_W-1:0]            wrOff  [NUM_SLOTS],
  input  logic [NUM_SLOTS*DATA_W-1:0] wrData,
  input  logic [NUM_SLOTS*ADDR_W-1:0] rdAddrA,
  input  logic [NUM_SLOTS*ADDR_W-1:0] rdAddrB,
  output logic [NUM_SLOTS*DATA_W-1:0] rdDataA,
  output logic [NUM_SLOTS*DATA_W-1:0] rdDataB
);

  logic [DATA_W-1:0] bankMem [NUM_SLOTS][REGS_PER_BANK];
  // portB[b][s]: bank b serving slot s's operand B at slot s's offset
  logic [DATA_W-1:0] portB   [NUM_SLOTS][NUM_SLOTS];
  logic [DATA_W-1:0] dataB   [NUM_SLOTS];

  for (genvar b = 0; b < NUM_SLOTS; b++) begin : g_bank
    // single write port, owned by slot b
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < REGS_PER_BANK; i++) bankMem[b][i] <= '0;
      end else if (strobe[b].commit) begin
        bankMem[b][wrOff[b]] <= wrData[b*DATA_W +: DATA_W];
      end
    end

    // own-slot operand A: bank bits of the address are not looked at
    assign rdDataA[b*DATA_W +: DATA_W] = bankMem[b][rdAddrA[b*ADDR_W +: OFF_W]];

    // operand B ports: one per slot
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_bport
      assign portB[b][s] = bankMem[b][rdAddrB[s*ADDR_W +: OFF_W]];
    end

    // R2: a committed write is found at its offset on the next cycle
    p_commit_lands_r2: assert property (@(posedge clk) disable iff (rst)
      strobe[b].commit |=> bankMem[b][$past(wrOff[b])] == $past(wrData[b*DATA_W +: DATA_W]));

    // R4: without a commit the addressed word keeps its value
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !strobe[b].commit |=> bankMem[b][$past(wrOff[b])] == $past(bankMem[b][wrOff[b]]));
  end

  // bank multiplexer for operand B
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_bmux
    logic [BANK_W-1:0] selBank;
    assign selBank = rdAddrB[s*ADDR_W+OFF_W +: BANK_W];

    always_comb begin
      dataB[s] = '0;
      for (int b = 0; b < NUM_SLOTS; b++) begin
        if (selBank == BANK_W'(b)) dataB[s] = portB[b][s];
      end
    end

    assign rdDataB[s*DATA_W +: DATA_W] = dataB[s];
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int NUM_SLOTS     = 2,
  parameter int REGS_PER_BANK = 16,
  parameter int DATA_W        = 32,
  localparam int OFF_W        = $clog2(REGS_PER_BANK),
  localparam int BANK_W       = $clog2(NUM_SLOTS),
  localparam int ADDR_W       = OFF_W + BANK_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SLOTS*ADDR_W-1:0] rdAddrA,
  input  logic [NUM_SLOTS*ADDR_W-1:0] rdAddrB,
  output logic [NUM_SLOTS*DATA_W-1:0] rdDataA,
  output logic [NUM_SLOTS*DATA_W-1:0] rdDataB,
  input  logic [NUM_SLOTS-1:0]        wrEn,
  input  logic [NUM_SLOTS*ADDR_W-1:0] wrAddr,
  input  logic [NUM_SLOTS*DATA_W-1:0] wrData,
  output logic [NUM_SLOTS-1:0]        badWrite
);

  wrStrobe_t        strobe [NUM_SLOTS];
  logic [OFF_W-1:0] wrOff  [NUM_SLOTS];

  banked_regfile_ctrl #(
    .NUM_SLOTS (NUM_SLOTS),
    .OFF_W     (OFF_W),
    .BANK_W    (BANK_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .strobe   (strobe),
    .wrOff    (wrOff),
    .badWrite (badWrite)
  );

  banked_regfile_dp #(
    .NUM_SLOTS     (NUM_SLOTS),
    .REGS_PER_BANK (REGS_PER_BANK),
    .DATA_W        (DATA_W),
    .OFF_W         (OFF_W),
    .BANK_W        (BANK_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .wrOff   (wrOff),
    .wrData  (wrData),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

  localparam int NS = 2;
  localparam int AW = 5;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NS*AW-1:0] rdAddrA, rdAddrB, wrAddr;
  logic [NS*DW-1:0] rdDataA, rdDataB, wrData;
  logic [NS-1:0]    wrEn, badWrite;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .badWrite(badWrite)
  );

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idleIn();
    wrEn = '0; wrAddr = '0; wrData = '0; rdAddrA = '0; rdAddrB = '0;
  endtask

  task automatic setWr(int s, int a, logic [DW-1:0] d);
    wrEn[s] = 1'b1;
    wrAddr[s*AW +: AW] = AW'(a);
    wrData[s*DW +: DW] = d;
  endtask

  function automatic logic [DW-1:0] getA(int s); return rdDataA[s*DW +: DW]; endfunction
  function automatic logic [DW-1:0] getB(int s); return rdDataB[s*DW +: DW]; endfunction

  // read any register through slot 0 operand B
  task automatic peek(string tag, int a, logic [DW-1:0] exp);
    rdAddrB[0 +: AW] = AW'(a);
    #1 check(tag, getB(0), exp);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    for (int a = 0; a < 32; a += 15) peek("R9 reset reg", a, '0);
    peek("R9 reset reg31", 31, '0);
    check("R9 reset flags", DW'(badWrite), '0);
  endtask

  task automatic t_single_write();
    @(negedge clk); setWr(0, 3, 32'h1111_0003);
    @(negedge clk); idleIn();
    rdAddrA[0 +: AW] = AW'(3);
    rdAddrB[AW +: AW] = AW'(3);
    #1;
    check("R2 slot0 A r3", getA(0), 32'h1111_0003);
    check("R1 slot1 B r3 bank0", getB(1), 32'h1111_0003);
    peek("R1 r19 untouched", 19, '0);
  endtask

  task automatic t_dual_write();
    @(negedge clk); setWr(0, 0, 32'hAAAA_0000); setWr(1, 16, 32'hBBBB_0016);
    @(negedge clk); idleIn();
    peek("R3 r0", 0, 32'hAAAA_0000);
    peek("R3 r16", 16, 32'hBBBB_0016);
  endtask

  task automatic t_foreign_write();
    @(negedge clk); setWr(0, 17, 32'hDEAD_0017); setWr(1, 20, 32'h2222_0020);
    @(negedge clk); idleIn();
    peek("R4 r17 unchanged", 17, '0);
    peek("R4 r1 unchanged", 1, '0);
    peek("R3 slot1 legal write kept", 20, 32'h2222_0020);
    check("R5 flag slot0", DW'(badWrite[0]), 1);
    check("R5 flag slot1 clear", DW'(badWrite[1]), 0);
    repeat (3) @(negedge clk);
    #1 check("R5 flag sticky", DW'(badWrite[0]), 1);
  endtask

  task automatic t_operand_a();
    @(negedge clk); setWr(0, 7, 32'h0000_7007); setWr(1, 23, 32'h0000_2323);
    @(negedge clk); idleIn();
    rdAddrA[0 +: AW]  = AW'(23);
    rdAddrA[AW +: AW] = AW'(7);
    #1;
    check("R6 slot0 A ignores bank bit", getA(0), 32'h0000_7007);
    check("R6 slot1 A ignores bank bit", getA(1), 32'h0000_2323);
  endtask

  task automatic t_cross_b();
    @(negedge clk);
    rdAddrB[0 +: AW]  = AW'(23);
    rdAddrB[AW +: AW] = AW'(7);
    #1;
    check("R7 slot0 B from bank1", getB(0), 32'h0000_2323);
    check("R7 slot1 B from bank0", getB(1), 32'h0000_7007);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    setWr(0, 7, 32'h0ABC_0007);
    rdAddrA[0 +: AW]  = AW'(7);
    rdAddrB[AW +: AW] = AW'(7);
    #1;
    check("R8 A old value before edge", getA(0), 32'h0000_7007);
    check("R8 B old value before edge", getB(1), 32'h0000_7007);
    @(negedge clk); wrEn = '0;
    #1;
    check("R8 A new value after edge", getA(0), 32'h0ABC_0007);
    check("R8 B new value after edge", getB(1), 32'h0ABC_0007);
  endtask

  task automatic t_all_reads();
    @(negedge clk); idleIn();
    rdAddrA[AW +: AW] = AW'(16);
    rdAddrB[0 +: AW]  = AW'(20);
    rdAddrB[AW +: AW] = AW'(23);
    rdAddrA[0 +: AW]  = AW'(0);
    #1;
    check("R10 slot1 A r16", getA(1), 32'hBBBB_0016);
    check("R10 slot0 B r20", getB(0), 32'h2222_0020);
    check("R10 slot1 B r23", getB(1), 32'h0000_2323);
    check("R10 slot0 A r0", getA(0), 32'hAAAA_0000);
  endtask

  task automatic t_reset_again();
    @(negedge clk); idleIn(); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    peek("R9 r7 cleared", 7, '0);
    peek("R9 r23 cleared", 23, '0);
    check("R9 flags cleared", DW'(badWrite), '0);
  endtask

  initial begin
    idleIn();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_single_write();
    t_dual_write();
    t_foreign_write();
    t_operand_a();
    t_cross_b();
    t_same_cycle();
    t_all_reads();
    t_reset_again();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule